// File: doc/BRIEF.md
# Hamming (7,4) Single-Error Codec

This block contains an encoder and a decoder for a single-error-correcting Hamming code with even parity. The encoder takes a 4-bit message and spreads it over a 7-bit codeword. The decoder takes a received 7-bit word, checks its three parity groups, and returns the message together with a syndrome, an error flag and a corrected flag.

The encoder and the decoder run independently of each other. Each has its own valid input, and each returns its result one clock later with a matching valid output. A mode input chooses how the decoder treats a nonzero syndrome. In correct mode it repairs the bit that the syndrome points at. In detect-only mode it reports the error and leaves every bit as received.

The code size is set by the parameter `PAR_W`, the number of parity bits. The codeword length and the message width are derived from it. The default of 3 gives the (7,4) code.

Top module: `hamming_codec`

## Requirements
- R1: Codeword bit index i-1 holds position i (positions 7 down to 1). Positions 1, 2 and 4 carry parity, and positions 7, 6, 5 and 3 carry the message from MSB to LSB. Each parity bit gives even parity over the positions whose index has that parity's bit set: bit 1 covers 1,3,5,7; bit 2 covers 2,3,6,7; bit 4 covers 4,5,6,7. As an example, message 1101 encodes to 1100110.
- R2: Any codeword produced by the encoder, fed unchanged to the decoder, gives syndrome 000, error 0, corrected 0, and the original message.
- R3: The syndrome is the three parity checks read as a binary number, with the check over position 4 as MSB. A single flipped bit at position p gives syndrome p. For example, received word 1110110 gives syndrome 101. A flip in a parity position gives a one-hot syndrome, and a flip in position 7 gives 111.
- R4: In correct mode (mode_correct=1), a nonzero syndrome inverts the bit at that position before extraction and raises both the error flag and the corrected flag. A single-bit error therefore returns the original message.
- R5: In detect-only mode (mode_correct=0), any 1- or 2-bit error raises the error flag. The corrected flag stays 0. The data output is the received positions 7, 6, 5 and 3, unaltered.
- R6: A zero syndrome passes the data through unchanged, with error and corrected both 0, in either mode.
- R7: Each valid output goes high exactly one cycle after its valid input. While the valid input is low, the matching data outputs keep their last values.
- R8: During reset, both valid outputs, the codeword, the data, the syndrome and both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_correct | input | 1 | 1 = correct single errors, 0 = detect only |
| enc_valid | input | 1 | Message present on enc_data |
| enc_data | input | 4 | Message to encode, MSB first |
| enc_out_valid | output | 1 | enc_code holds a new codeword |
| enc_code | output | 7 | Codeword, bit i-1 = position i |
| dec_valid | input | 1 | Word present on dec_word |
| dec_word | input | 7 | Received word, bit i-1 = position i |
| dec_out_valid | output | 1 | Decoder outputs hold a new result |
| dec_data | output | 4 | Extracted (possibly repaired) message |
| dec_syndrome | output | 3 | Parity-check result, position of a single error |
| dec_error | output | 1 | Syndrome was nonzero |
| dec_corrected | output | 1 | A bit was inverted before extraction |

## Verification
The bench builds the block only with `PAR_W` = 3, the (7,4) code. At that size all 16 messages and all 7 error positions are small enough for random stimulus to cover them many times over. The random stimulus mixes zero, one and two flipped bits with both mode settings, so it reaches miscorrection of double errors in correct mode as well as plain reporting in detect-only mode. Directed cases cover the example word from the requirements, flips in parity positions, and a flip in position 7.

// File: rtl/ham_pkg.sv
package ham_pkg;

  typedef enum logic {
    MODE_DETECT  = 1'b0,
    MODE_CORRECT = 1'b1
  } mode_e;

  // Positions that are powers of two carry parity
  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/ham_enc.sv
module ham_enc #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int MSG_W = CW_W - PAR_W
) (
  input  logic [MSG_W-1:0] msg,
  output logic [CW_W-1:0]  code
);

  // Scatter message bits onto non-parity positions, highest position first
  function automatic logic [CW_W-1:0] scatter(input logic [MSG_W-1:0] d);
    logic [CW_W-1:0] w;
    int k;
    w = '0;
    k = MSG_W - 1;
    for (int pos = CW_W; pos >= 1; pos--) begin
      if (!ham_pkg::is_pow2(pos)) begin
        w[pos-1] = d[k];
        k--;
      end
    end
    return w;
  endfunction

  // Even parity over each position group, written to position 2^j
  function automatic logic [CW_W-1:0] add_parity(input logic [CW_W-1:0] w);
    logic [CW_W-1:0] r;
    logic p;
    r = w;
    for (int j = 0; j < PAR_W; j++) begin
      p = 1'b0;
      for (int pos = 1; pos <= CW_W; pos++) begin
        if (pos[j]) p = p ^ w[pos-1];
      end
      r[(1 << j) - 1] = p;
    end
    return r;
  endfunction

  always_comb code = add_parity(scatter(msg));

endmodule

// File: rtl/ham_dec.sv
module ham_dec #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int MSG_W = CW_W - PAR_W
) (
  input  logic [CW_W-1:0]  word,
  input  logic             correct_en,
  output logic [PAR_W-1:0] syndrome,
  output logic [CW_W-1:0]  flip_mask,
  output logic [MSG_W-1:0] data,
  output logic             error,
  output logic             corrected
);

  function automatic logic [PAR_W-1:0] check(input logic [CW_W-1:0] w);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int j = 0; j < PAR_W; j++) begin
      for (int pos = 1; pos <= CW_W; pos++) begin
        if (pos[j]) s[j] = s[j] ^ w[pos-1];
      end
    end
    return s;
  endfunction

  // Gather data positions back into a message, MSB from highest position
  function automatic logic [MSG_W-1:0] gather(input logic [CW_W-1:0] w);
    logic [MSG_W-1:0] d;
    int k;
    d = '0;
    k = MSG_W - 1;
    for (int pos = CW_W; pos >= 1; pos--) begin
      if (!ham_pkg::is_pow2(pos)) begin
        d[k] = w[pos-1];
        k--;
      end
    end
    return d;
  endfunction

  logic syn_nz;

  always_comb begin
    syndrome  = check(word);
    syn_nz    = |syndrome;
    flip_mask = '0;
    if (correct_en && syn_nz) flip_mask[syndrome - PAR_W'(1)] = 1'b1;
    data      = gather(word ^ flip_mask);
    error     = syn_nz;
    corrected = correct_en && syn_nz;
  end

endmodule

// File: rtl/hamming_codec.sv
module hamming_codec #(
  parameter int PAR_W = 3,
  localparam int CW_W = (1 << PAR_W) - 1,
  localparam int MSG_W = CW_W - PAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_correct,
  input  logic             enc_valid,
  input  logic [MSG_W-1:0] enc_data,
  output logic             enc_out_valid,
  output logic [CW_W-1:0]  enc_code,
  input  logic             dec_valid,
  input  logic [CW_W-1:0]  dec_word,
  output logic             dec_out_valid,
  output logic [MSG_W-1:0] dec_data,
  output logic [PAR_W-1:0] dec_syndrome,
  output logic             dec_error,
  output logic             dec_corrected
);

  ham_pkg::mode_e   mode;
  logic [CW_W-1:0]  enc_code_c;
  logic [PAR_W-1:0] syn_c;
  logic [CW_W-1:0]  flip_c;
  logic [MSG_W-1:0] data_c;
  logic             err_c;
  logic             cor_c;

  assign mode = ham_pkg::mode_e'(mode_correct);

  ham_enc #(.PAR_W(PAR_W)) u_enc (
    .msg  (enc_data),
    .code (enc_code_c)
  );

  ham_dec #(.PAR_W(PAR_W)) u_dec (
    .word       (dec_word),
    .correct_en (mode == ham_pkg::MODE_CORRECT),
    .syndrome   (syn_c),
    .flip_mask  (flip_c),
    .data       (data_c),
    .error      (err_c),
    .corrected  (cor_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_out_valid <= 1'b0;
      enc_code      <= '0;
    end else begin
      enc_out_valid <= enc_valid;
      if (enc_valid) enc_code <= enc_code_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_out_valid <= 1'b0;
      dec_data      <= '0;
      dec_syndrome  <= '0;
      dec_error     <= 1'b0;
      dec_corrected <= 1'b0;
    end else begin
      dec_out_valid <= dec_valid;
      if (dec_valid) begin
        dec_data      <= data_c;
        dec_syndrome  <= syn_c;
        dec_error     <= err_c;
        dec_corrected <= cor_c;
      end
    end
  end

  // R7
  enc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> enc_out_valid);

  // R7
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (!dec_out_valid && $stable(dec_data) && $stable(dec_syndrome)));

  // R4
  flip_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flip_c));

  // R5
  detect_nofix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !mode_correct) |=> !dec_corrected);

  // R6
  zero_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_out_valid && dec_syndrome == '0) |-> (!dec_error && !dec_corrected));

endmodule

// File: tb/hamming_codec_bench.sv
module hamming_codec_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_correct = 1'b0;
  logic       enc_valid = 1'b0;
  logic [3:0] enc_data = '0;
  logic       enc_out_valid;
  logic [6:0] enc_code;
  logic       dec_valid = 1'b0;
  logic [6:0] dec_word = '0;
  logic       dec_out_valid;
  logic [3:0] dec_data;
  logic [2:0] dec_syndrome;
  logic       dec_error;
  logic       dec_corrected;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_codec #(.PAR_W(3)) u_hamming_codec (
    .clk, .rst_n, .mode_correct,
    .enc_valid, .enc_data, .enc_out_valid, .enc_code,
    .dec_valid, .dec_word, .dec_out_valid, .dec_data,
    .dec_syndrome, .dec_error, .dec_corrected
  );

  function automatic logic [6:0] ref_enc(input logic [3:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p4, d[0], p2, p1};
  endfunction

  function automatic logic [2:0] ref_syn(input logic [6:0] w);
    return {w[3] ^ w[4] ^ w[5] ^ w[6],
            w[1] ^ w[2] ^ w[5] ^ w[6],
            w[0] ^ w[2] ^ w[4] ^ w[6]};
  endfunction

  function automatic logic [3:0] ref_ext(input logic [6:0] w);
    return {w[6], w[5], w[4], w[2]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_enc(input logic [3:0] d, input string req);
    logic [6:0] e;
    e = ref_enc(d);
    @(negedge clk);
    enc_valid = 1'b1;
    enc_data  = d;
    @(negedge clk);
    enc_valid = 1'b0;
    chk(enc_out_valid == 1'b1, {req, " R7 enc valid"}, enc_out_valid, 1);
    chk(enc_code == e, req, enc_code, e);
  endtask

  task automatic do_dec(input logic [6:0] w, input bit mode, input string req,
                        input bit chk_msg, input logic [3:0] msg);
    logic [2:0] s;
    logic [3:0] ed;
    logic [6:0] fixed;
    s = ref_syn(w);
    fixed = w;
    if (mode && s != 0) fixed[s - 3'd1] = ~fixed[s - 3'd1];
    ed = ref_ext(fixed);
    @(negedge clk);
    dec_valid    = 1'b1;
    dec_word     = w;
    mode_correct = mode;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(dec_out_valid == 1'b1, {req, " R7 dec valid"}, dec_out_valid, 1);
    chk(dec_syndrome == s, {req, " R3 syndrome"}, dec_syndrome, s);
    chk(dec_data == ed, {req, " data"}, dec_data, ed);
    chk(dec_error == (s != 0), {req, " error"}, dec_error, s != 0);
    chk(dec_corrected == (mode && s != 0), {req, " corrected"}, dec_corrected, mode && s != 0);
    if (chk_msg) chk(dec_data == msg, {req, " message"}, dec_data, msg);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(enc_out_valid == 0 && dec_out_valid == 0, "R8 valids", {enc_out_valid, dec_out_valid}, 0);
    chk(enc_code == 0 && dec_data == 0 && dec_syndrome == 0, "R8 data", {enc_code, dec_data, dec_syndrome}, 0);
    chk(dec_error == 0 && dec_corrected == 0, "R8 flags", {dec_error, dec_corrected}, 0);
    rst_n = 1'b1;

    // R1 worked example
    do_enc(4'b1101, "R1 example");
    chk(enc_code == 7'b1100110, "R1 literal", enc_code, 7'b1100110);
    // R7 hold after valid drops
    @(negedge clk);
    chk(enc_out_valid == 0, "R7 enc valid drop", enc_out_valid, 0);
    chk(enc_code == 7'b1100110, "R7 enc hold", enc_code, 7'b1100110);

    // R3 and R4: the worked error word
    do_dec(7'b1110110, 1'b1, "R4 example", 1'b1, 4'b1101);
    chk(dec_syndrome == 3'b101, "R3 literal", dec_syndrome, 3'b101);
    @(negedge clk);
    chk(dec_out_valid == 0, "R7 dec valid drop", dec_out_valid, 0);
    chk(dec_data == 4'b1101, "R7 dec hold", dec_data, 4'b1101);
    // R5 same word in detect-only mode
    do_dec(7'b1110110, 1'b0, "R5 example", 1'b1, 4'b1111);
    // R3 parity position and position 7 flips
    do_dec(7'b1100111, 1'b1, "R3 pos1", 1'b1, 4'b1101);
    chk(dec_syndrome == 3'b001, "R3 pos1 literal", dec_syndrome, 3'b001);
    do_dec(7'b1101110, 1'b1, "R3 pos4", 1'b1, 4'b1101);
    chk(dec_syndrome == 3'b100, "R3 pos4 literal", dec_syndrome, 3'b100);
    do_dec(7'b0100110, 1'b1, "R3 pos7", 1'b1, 4'b1101);
    chk(dec_syndrome == 3'b111, "R3 pos7 literal", dec_syndrome, 3'b111);
    // R6 clean word in both modes
    do_dec(7'b1100110, 1'b0, "R6 clean detect", 1'b1, 4'b1101);
    do_dec(7'b1100110, 1'b1, "R6 clean correct", 1'b1, 4'b1101);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      logic [6:0] cw, w;
      int nerr, pa, pb;
      bit md;
      m = 4'($urandom_range(0, 15));
      do_enc(m, "R1 random");
      cw = ref_enc(m);
      nerr = $urandom_range(0, 2);
      md = 1'($urandom_range(0, 1));
      pa = $urandom_range(0, 6);
      pb = (pa + 1 + $urandom_range(0, 5)) % 7;
      w = cw;
      if (nerr >= 1) w[pa] = ~w[pa];
      if (nerr == 2) w[pb] = ~w[pb];
      if (nerr == 0)
        do_dec(w, md, "R2 clean", 1'b1, m);
      else if (nerr == 1 && md)
        do_dec(w, md, "R4 single", 1'b1, m);
      else if (!md) begin
        do_dec(w, md, "R5 detect", 1'b1, ref_ext(w));
        chk(dec_error == 1'b1, "R5 flag", dec_error, 1);
      end else
        do_dec(w, md, "R4 double", 1'b0, 4'b0);
    end

    finish_run();
  end

endmodule